// File: doc/BRIEF.md
# Multi-Operand Carry-Save Adder Tree

This block adds a configurable number of equal-width operands in one combinational pass. Any operand can be marked for subtraction at run time through a mask. Every operand is widened to the result width, either by zero fill or by sign fill. A subtracted operand is then bit-inverted. A single correction term, equal to the number of subtracted operands, supplies the missing "+1" of each two's-complement negation.

All widened terms go through a chain of word-wide 3:2 carry-save rows until two vectors remain. One carry-propagate adder then forms the result, which wraps modulo two to the power of the output width. A nested difference such as c − (a − b) is given to the block already flattened, as c − a + b. It therefore costs no second adder.

The block also reports on a port how many 3:2 rows it instantiated. An integrator can use this to confirm the structure chosen for a parameter set.

Top module: `csa_sum_tree`

## Requirements
- R1: With an empty subtract mask, `sumOut` equals the arithmetic sum of all operands taken modulo 2^OUT_W. With all-zero inputs, `sumOut` is 0.
- R2: Mask bit i set (bit 0 belongs to the operand in the lowest `opsIn` slice) makes operand i count negatively. The result is the signed-term sum modulo 2^OUT_W.
- R3: `treeRows` equals T − 2, where T is NUM_OPS plus one correction term when SUB_EN is 1 (0 when T < 3). For 3 operands with subtraction the value is 2. For 4 operands with subtraction, or 5 without, it is 3.
- R4: With SIGNED_OPS = 1, each operand is a two's-complement value whose most significant bit is repeated into the upper result bits before summation.
- R5: With SIGNED_OPS = 0 and OUT_W > IN_W, operands are zero-filled, so carries out of the operand width appear in the result (three 3-bit operands of 7 give 21 at a 5-bit output).
- R6: With SUB_EN = 0, the subtract mask has no effect on `sumOut` and no correction term exists.
- R7: With every mask bit set, the result is the negated operand sum modulo 2^OUT_W (operands 1, 2, 3 at 5 bits give 26).
- R8: A nested difference c − (a − b), supplied as mask "a subtracted, b and c added", yields c − a + b (a = 5, b = 6, c = 2 gives 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opsIn | input | NUM_OPS*IN_W | Packed operands, operand i in bits [i*IN_W +: IN_W] |
| subMask | input | NUM_OPS | Bit i set subtracts operand i |
| sumOut | output | OUT_W | Truncated signed-term sum |
| treeRows | output | 8 | Number of 3:2 compressor rows built |

## Verification
Sign fill and the two's-complement correction term act together in one evaluation whenever a signed operand that is marked for subtraction is negative. The inverted sign bits and the correction constant must then cancel exactly across the widened bits. The signed configuration is swept over every operand pattern under every one of the sixteen masks, which provokes this overlap many times. Each result is judged against an integer sum that the bench forms by sign-interpreting, negating and wrapping each operand. The unsigned configuration receives the same mask-times-operand sweep so that zero fill and correction are judged together as well.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int CORR_W = 8;

  typedef struct packed {
    logic              anySub;
    logic [CORR_W-1:0] corrCount;
  } termCtrl_t;

  function automatic int termCount(input int nOps, input bit subEn);
    return subEn ? nOps + 1 : nOps;
  endfunction

  function automatic int compressorCount(input int nTerms);
    return (nTerms >= 3) ? nTerms - 2 : 0;
  endfunction
endpackage

// File: rtl/csa_term_ctrl.sv
module csa_term_ctrl
  import csa_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter bit SUB_EN  = 1'b1
) (
  input  logic [NUM_OPS-1:0] subMask,
  output termCtrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    if (SUB_EN) begin
      for (int i = 0; i < NUM_OPS; i++) begin
        if (subMask[i]) begin
          ctrl.anySub    = 1'b1;
          ctrl.corrCount = ctrl.corrCount + CORR_W'(1);
        end
      end
    end
  end

  // R2: the correction strobe and the correction count must agree
  always_comb begin
    a_r2_strobe_agrees: assert (ctrl.anySub == (ctrl.corrCount != '0));
  end
endmodule

// File: rtl/csa_term_prep.sv
module csa_term_prep
  import csa_pkg::*;
#(
  parameter int NUM_OPS    = 4,
  parameter int IN_W       = 4,
  parameter int OUT_W      = 6,
  parameter bit SIGNED_OPS = 1'b0,
  parameter bit SUB_EN     = 1'b1,
  localparam int NT        = termCount(NUM_OPS, SUB_EN)
) (
  input  logic [NUM_OPS*IN_W-1:0] opsIn,
  input  logic [NUM_OPS-1:0]      subMask,
  input  termCtrl_t               ctrl,
  output logic [NT*OUT_W-1:0]     termsOut
);
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic [IN_W-1:0]  raw;
    logic [OUT_W-1:0] ext;
    logic [OUT_W-1:0] term;
    logic             doSub;

    assign raw   = opsIn[i*IN_W +: IN_W];
    assign doSub = SUB_EN && subMask[i];

    always_comb begin
      for (int b = 0; b < OUT_W; b++) begin
        if (b < IN_W) ext[b] = raw[(b < IN_W) ? b : IN_W-1];
        else          ext[b] = SIGNED_OPS ? raw[IN_W-1] : 1'b0;
      end
    end

    assign term = doSub ? ~ext : ext;
    assign termsOut[i*OUT_W +: OUT_W] = term;

    // R2: a subtracted term is the one's complement of its widened operand
    always_comb begin
      if (doSub) a_r2_term_inverted: assert (OUT_W'(term + ext) == '1);
    end

    if (OUT_W > IN_W) begin : g_wide
      if (SIGNED_OPS) begin : g_sgn
        // R4: bits from the operand sign upward are uniform
        always_comb begin
          a_r4_sign_fill: assert ((term[OUT_W-1:IN_W-1] == '0) ||
                                  (term[OUT_W-1:IN_W-1] == '1));
        end
      end else begin : g_uns
        // R5: an added unsigned operand contributes no upper bits
        always_comb begin
          if (!doSub) a_r5_zero_fill: assert (term[OUT_W-1:IN_W] == '0);
        end
      end
    end
  end

  if (SUB_EN) begin : g_corr
    logic [OUT_W-1:0] corrVec;
    always_comb begin
      corrVec = '0;
      if (ctrl.anySub) begin
        for (int b = 0; b < OUT_W; b++) begin
          if (b < CORR_W) corrVec[b] = ctrl.corrCount[(b < CORR_W) ? b : 0];
        end
      end
    end
    assign termsOut[NUM_OPS*OUT_W +: OUT_W] = corrVec;
  end
endmodule

// File: rtl/csa_reduce_tree.sv
module csa_reduce_tree
  import csa_pkg::*;
#(
  parameter int NT = 5,
  parameter int W  = 6,
  localparam int NC = compressorCount(NT),
  localparam int NV = NT + 2 * NC
) (
  input  logic [NT*W-1:0] termsIn,
  output logic [W-1:0]    sumOut,
  output logic [7:0]      treeRows
);
  logic [W-1:0] vecs [NV];
  logic [W-1:0] xIn, yIn, zIn;
  logic [7:0]   rowTally;

  // Each row consumes the three oldest pending vectors and appends a
  // sum vector and a shifted carry vector to the queue.
  always_comb begin
    rowTally = '0;
    xIn = '0;
    yIn = '0;
    zIn = '0;
    for (int i = 0; i < NT; i++) vecs[i] = termsIn[i*W +: W];
    for (int i = NT; i < NV; i++) vecs[i] = '0;
    for (int k = 0; k < NC; k++) begin
      xIn = vecs[3*k];
      yIn = vecs[3*k+1];
      zIn = vecs[3*k+2];
      vecs[NT+2*k]   = xIn ^ yIn ^ zIn;
      vecs[NT+2*k+1] = ((xIn & yIn) | (xIn & zIn) | (yIn & zIn)) << 1;
      rowTally = rowTally + 8'd1;
    end
  end

  assign treeRows = rowTally;

  if (NT == 1) begin : g_pass
    assign sumOut = vecs[0];
  end else begin : g_cpa
    assign sumOut = vecs[NV-2] + vecs[NV-1];
  end

  // R1: every 3:2 row keeps the modular total of its inputs
  always_comb begin
    for (int k = 0; k < NC; k++) begin
      a_r1_row_preserves: assert (W'(vecs[3*k] + vecs[3*k+1] + vecs[3*k+2]) ==
                                  W'(vecs[NT+2*k] + vecs[NT+2*k+1]));
    end
  end

  // R1: the final adder output equals the plain sum of the tree inputs
  logic [W-1:0] refAcc;
  always_comb begin
    refAcc = '0;
    for (int i = 0; i < NT; i++) refAcc = refAcc + termsIn[i*W +: W];
    a_r1_tree_total: assert (refAcc == sumOut);
  end
endmodule

// File: rtl/csa_sum_tree.sv
module csa_sum_tree
  import csa_pkg::*;
#(
  parameter int NUM_OPS    = 4,
  parameter int IN_W       = 4,
  parameter int OUT_W      = 6,
  parameter bit SIGNED_OPS = 1'b0,
  parameter bit SUB_EN     = 1'b1
) (
  input  logic [NUM_OPS*IN_W-1:0] opsIn,
  input  logic [NUM_OPS-1:0]      subMask,
  output logic [OUT_W-1:0]        sumOut,
  output logic [7:0]              treeRows
);
  localparam int NT = termCount(NUM_OPS, SUB_EN);

  termCtrl_t             ctrl;
  logic [NT*OUT_W-1:0]   terms;

  csa_term_ctrl #(.NUM_OPS(NUM_OPS), .SUB_EN(SUB_EN)) ctrl_i (
    .subMask (subMask),
    .ctrl    (ctrl)
  );

  csa_term_prep #(
    .NUM_OPS(NUM_OPS), .IN_W(IN_W), .OUT_W(OUT_W),
    .SIGNED_OPS(SIGNED_OPS), .SUB_EN(SUB_EN)
  ) prep_i (
    .opsIn    (opsIn),
    .subMask  (subMask),
    .ctrl     (ctrl),
    .termsOut (terms)
  );

  csa_reduce_tree #(.NT(NT), .W(OUT_W)) tree_i (
    .termsIn  (terms),
    .sumOut   (sumOut),
    .treeRows (treeRows)
  );
endmodule

// File: tb/csa_sum_tree_tb.sv
module csa_sum_tree_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // unsigned, subtraction enabled: 3 ops x 3 bits -> 5 bits
  logic [8:0]  opsU  = '0;
  logic [2:0]  maskU = '0;
  logic [4:0]  sumU;
  logic [7:0]  rowsU;
  // signed, subtraction enabled: 4 ops x 3 bits -> 5 bits
  logic [11:0] opsS  = '0;
  logic [3:0]  maskS = '0;
  logic [4:0]  sumS;
  logic [7:0]  rowsS;
  // unsigned, no subtraction: 5 ops x 4 bits -> 4 bits
  logic [19:0] opsN  = '0;
  logic [4:0]  maskN = '0;
  logic [3:0]  sumN;
  logic [7:0]  rowsN;

  csa_sum_tree #(.NUM_OPS(3), .IN_W(3), .OUT_W(5), .SIGNED_OPS(1'b0), .SUB_EN(1'b1)) dut_i (
    .opsIn(opsU), .subMask(maskU), .sumOut(sumU), .treeRows(rowsU));
  csa_sum_tree #(.NUM_OPS(4), .IN_W(3), .OUT_W(5), .SIGNED_OPS(1'b1), .SUB_EN(1'b1)) dutSgn_i (
    .opsIn(opsS), .subMask(maskS), .sumOut(sumS), .treeRows(rowsS));
  csa_sum_tree #(.NUM_OPS(5), .IN_W(4), .OUT_W(4), .SIGNED_OPS(1'b0), .SUB_EN(1'b0)) dutNoSub_i (
    .opsIn(opsN), .subMask(maskN), .sumOut(sumN), .treeRows(rowsN));

  function automatic int refSum(input logic [63:0] ops, input int n, input int inW,
                                input int outW, input bit sgn, input logic [15:0] mask,
                                input bit subEn);
    int acc = 0;
    for (int i = 0; i < n; i++) begin
      int v;
      v = int'((ops >> (i*inW)) & 64'((1 << inW) - 1));
      if (sgn && v >= (1 << (inW-1))) v = v - (1 << inW);
      if (subEn && mask[i]) acc = acc - v;
      else                  acc = acc + v;
    end
    return acc & ((1 << outW) - 1);
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    // R1: all-zero inputs give zero
    check("R1 zero inputs U", int'(sumU), 0);
    check("R1 zero inputs S", int'(sumS), 0);
    check("R1 zero inputs N", int'(sumN), 0);
    // R3: compressor rows per configuration
    check("R3 rows 3ops+corr", int'(rowsU), 2);
    check("R3 rows 4ops+corr", int'(rowsS), 3);
    check("R3 rows 5ops", int'(rowsN), 3);

    // R1/R2: exhaustive unsigned sweep under every mask
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 512; v++) begin
        @(posedge clk);
        opsU = 9'(v); maskU = 3'(m);
        @(negedge clk);
        check((m == 0) ? "R1 unsigned sum" : "R2 masked subtract", int'(sumU),
              refSum(64'(opsU), 3, 3, 5, 1'b0, 16'(maskU), 1'b1));
      end
    end

    // R5: zero fill lets carries reach the wider output
    @(posedge clk); opsU = {3'd7, 3'd7, 3'd7}; maskU = 3'b000;
    @(negedge clk); check("R5 zero fill", int'(sumU), 21);
    // R7: every operand subtracted
    @(posedge clk); opsU = {3'd3, 3'd2, 3'd1}; maskU = 3'b111;
    @(negedge clk); check("R7 all subtracted", int'(sumU), 26);
    // R8: c - (a - b) flattened to c - a + b
    @(posedge clk); opsU = {3'd2, 3'd6, 3'd5}; maskU = 3'b001;
    @(negedge clk); check("R8 nested difference", int'(sumU), 3);

    // R4: exhaustive signed sweep under every mask
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 4096; v++) begin
        @(posedge clk);
        opsS = 12'(v); maskS = 4'(m);
        @(negedge clk);
        check("R4 signed sum", int'(sumS),
              refSum(64'(opsS), 4, 3, 5, 1'b1, 16'(maskS), 1'b1));
      end
    end
    @(posedge clk); opsS = {4{3'b100}}; maskS = 4'b0000;
    @(negedge clk); check("R4 most negative operands", int'(sumS), 16);

    // R1: wrap at equal width
    @(posedge clk); opsN = {5{4'd15}}; maskN = 5'b00000;
    @(negedge clk); check("R1 wrap", int'(sumN), 11);
    // R6: mask has no effect without subtraction support
    @(posedge clk); maskN = 5'b11111;
    @(negedge clk); check("R6 mask ignored all ones", int'(sumN), 11);
    for (int r = 0; r < 2000; r++) begin
      @(posedge clk);
      opsN = 20'($urandom); maskN = 5'($urandom);
      @(negedge clk);
      check("R6 mask ignored random", int'(sumN),
            refSum(64'(opsN), 5, 4, 4, 1'b0, 16'(maskN), 1'b0));
    end

    finishRun();
  end
endmodule